// File: doc/BRIEF.md
# Timer Output-Compare Channel

This block is one compare channel attached to a 16-bit timer/counter. It watches the running count, which the timer delivers together with a tick strobe and TOP/BOTTOM strobes. When the count equals the channel's compare value on a timer tick, the channel raises a match flag and updates an internal waveform bit. The compare-output mode field selects that update: toggle, clear or set in the non-PWM modes, and a non-inverted or inverted pulse train in PWM mode. The counter itself and its prescaler sit outside the block.

Software writes the compare value through a write port. In the two non-PWM modes (free-running and clear-on-compare) the write lands in the active compare register at once. In PWM mode it lands in a shadow register, and the shadow moves into the active register only on a tick at the chosen end of the count, so that no pulse is cut short. A force strobe applies the configured action without a real match. A notice that software has rewritten the counter masks matches for one tick. The waveform bit reaches the pin only when output compare is enabled and the pin is set as an output. Otherwise the pin carries the ordinary port value.

Top module: `ocu_channel`

## Requirements
- R1: Synchronous reset clears the match flag, the waveform bit and the active compare value to 0.
- R2: A match occurs on a clock edge where `tick` is 1 and `cnt_val` equals the active compare value. The flag is 1 from that edge on, so it is seen in the cycle after the tick.
- R3: In the non-PWM modes (`wave_mode` 0 = free-running, 1 = clear-on-compare), the `out_mode` code acts on a match as follows: 0 leaves the waveform bit alone, 1 toggles it, 2 clears it and 3 sets it.
- R4: A `force_strobe` in a non-PWM mode updates the waveform bit exactly as a match would, but it does not set the flag. In PWM mode the strobe is ignored.
- R5: A pulse on `cnt_written` suppresses any match on a tick in the same cycle and on the first tick in a later cycle. A suppressed match changes neither the flag nor the waveform bit.
- R6: When `wave_mode[1]` is 0, a compare write updates the active value at once. When `wave_mode[1]` is 1 (PWM), the write goes to the shadow register, and the shadow is copied to the active value on a tick with `at_top` set (parameter `LOAD_AT_TOP` = 1, the default) or with `at_bottom` set (0).
- R7: In PWM, `out_mode` 2 sets the waveform bit on a tick with `at_bottom` and clears it on a match. `out_mode` 3 does the opposite. Codes 0 and 1 leave the bit alone. When a match and BOTTOM fall on the same tick, the match action wins.
- R8: `pin_out` carries the waveform bit when `out_mode` is non-zero and `pin_dir_out` is 1. Otherwise it carries `port_val`.
- R9: Writing `flag_clr` = 1 or pulsing `irq_ack` clears the flag, but a match in the same cycle wins. `irq` is the flag ANDed with `irq_en`.
- R10: `out_mode` is not buffered: a new code applies from the next match. The waveform bit keeps its value when `wave_mode` changes, and it changes only on a tick or a force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer tick strobe |
| cnt_val | input | 16 | Current counter value |
| at_top | input | 1 | Counter is at TOP |
| at_bottom | input | 1 | Counter is at BOTTOM |
| wave_mode | input | 2 | 0 free-running, 1 clear-on-compare, 2/3 PWM |
| out_mode | input | 2 | Compare-output action code |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | 16 | Compare value write data |
| force_strobe | input | 1 | Force a match action on the waveform bit |
| cnt_written | input | 1 | Software wrote the counter this cycle |
| pin_dir_out | input | 1 | Pin direction, 1 = output |
| port_val | input | 1 | Ordinary port output value |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-one-to-clear of the match flag |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| match_flag | output | 1 | Match flag |
| irq | output | 1 | Interrupt request |
| pin_out | output | 1 | Pin value |

## Verification
A wrong active compare value shows up at the first tick where the count passes the intended value. The flag then fails to rise one cycle later, or the pin moves at the wrong count. A shadow that loads at the wrong moment in PWM only shows at the next tick whose count equals either the old or the new value, so the tests place such ticks between a write and its TOP tick. A stale suppression state, or a waveform bit that drifts, shows on the flag or the pin within one tick. The pin is also checked with the enable gating on and off.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

    typedef enum logic [1:0] {
        WM_FREE   = 2'd0,
        WM_CLRCMP = 2'd1,
        WM_PWM    = 2'd2,
        WM_PWM2   = 2'd3
    } wave_mode_e;

    typedef enum logic [1:0] {
        OM_OFF    = 2'd0,
        OM_TOGGLE = 2'd1,
        OM_LOW    = 2'd2,
        OM_HIGH   = 2'd3
    } out_mode_e;

    // Events seen by the waveform generator in one cycle
    typedef struct packed {
        logic hit;     // real, unblocked compare match
        logic forced;  // forced match (non-PWM only)
        logic bottom;  // tick at BOTTOM
    } wave_evt_t;

    function automatic logic mode_is_pwm(input wave_mode_e m);
        return m[1];
    endfunction

    // Next value of the waveform bit
    function automatic logic wave_next(input logic cur, input logic pwm,
                                       input out_mode_e om, input wave_evt_t ev);
        logic nxt;
        nxt = cur;
        if (!pwm) begin
            if (ev.hit || ev.forced) begin
                unique case (om)
                    OM_TOGGLE: nxt = ~cur;
                    OM_LOW:    nxt = 1'b0;
                    OM_HIGH:   nxt = 1'b1;
                    default:   nxt = cur;
                endcase
            end
        end else begin
            if (ev.hit) begin
                if (om == OM_LOW)       nxt = 1'b0;
                else if (om == OM_HIGH) nxt = 1'b1;
            end else if (ev.bottom) begin
                if (om == OM_LOW)       nxt = 1'b1;
                else if (om == OM_HIGH) nxt = 1'b0;
            end
        end
        return nxt;
    endfunction

endpackage

// File: rtl/ocu_cmp_reg.sv
module ocu_cmp_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pwm,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         tick,
    input  logic         load_pt,
    output logic [W-1:0] active
);
    logic [W-1:0] shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            active <= '0;
        end else begin
            if (wr) shadow <= wdata;
            if (!pwm && wr)
                active <= wdata;
            else if (pwm && tick && load_pt)
                active <= shadow;
        end
    end
endmodule

// File: rtl/ocu_match.sv
module ocu_match #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cnt_val,
    input  logic [W-1:0] cmp_val,
    input  logic         tick,
    input  logic         cnt_written,
    input  logic         flag_clr,
    input  logic         irq_ack,
    output logic         hit,
    output logic         armed,
    output logic         flag
);
    logic equal;
    logic blocked;

    assign equal   = (cnt_val == cmp_val);
    assign blocked = armed | cnt_written;
    assign hit     = tick & equal & ~blocked;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            flag  <= 1'b0;
        end else begin
            if (cnt_written)
                armed <= 1'b1;
            else if (tick)
                armed <= 1'b0;

            if (hit)
                flag <= 1'b1;
            else if (flag_clr || irq_ack)
                flag <= 1'b0;
        end
    end
endmodule

// File: rtl/ocu_wavegen.sv
module ocu_wavegen
    import ocu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pwm,
    input  out_mode_e om,
    input  logic      hit,
    input  logic      force_strobe,
    input  logic      tick,
    input  logic      at_bottom,
    input  logic      pin_dir_out,
    input  logic      port_val,
    output logic      wave_bit,
    output logic      pin_out
);
    wave_evt_t ev;

    always_comb begin
        ev.hit    = hit;
        ev.forced = force_strobe & ~pwm;
        ev.bottom = tick & at_bottom;
    end

    always_ff @(posedge clk) begin
        if (rst) wave_bit <= 1'b0;
        else     wave_bit <= wave_next(wave_bit, pwm, om, ev);
    end

    assign pin_out = ((om != OM_OFF) && pin_dir_out) ? wave_bit : port_val;
endmodule

// File: rtl/ocu_channel.sv
module ocu_channel
    import ocu_pkg::*;
#(
    parameter int W           = 16,
    parameter bit LOAD_AT_TOP = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] cnt_val,
    input  logic         at_top,
    input  logic         at_bottom,
    input  logic [1:0]   wave_mode,
    input  logic [1:0]   out_mode,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    input  logic         force_strobe,
    input  logic         cnt_written,
    input  logic         pin_dir_out,
    input  logic         port_val,
    input  logic         irq_en,
    input  logic         flag_clr,
    input  logic         irq_ack,
    output logic         match_flag,
    output logic         irq,
    output logic         pin_out
);
    wave_mode_e   wm;
    out_mode_e    om;
    logic         pwm;
    logic         load_pt;
    logic [W-1:0] cmp_active;
    logic         hit;
    logic         blk_armed;
    logic         ocx;

    assign wm  = wave_mode_e'(wave_mode);
    assign om  = out_mode_e'(out_mode);
    assign pwm = mode_is_pwm(wm);

    generate
        if (LOAD_AT_TOP) begin : g_load_top
            assign load_pt = at_top;
        end else begin : g_load_bottom
            assign load_pt = at_bottom;
        end
    endgenerate

    ocu_cmp_reg #(.W(W)) u_cmp (
        .clk(clk), .rst(rst), .pwm(pwm), .wr(cmp_wr), .wdata(cmp_wdata),
        .tick(tick), .load_pt(load_pt), .active(cmp_active)
    );

    ocu_match #(.W(W)) u_match (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .cmp_val(cmp_active),
        .tick(tick), .cnt_written(cnt_written), .flag_clr(flag_clr),
        .irq_ack(irq_ack), .hit(hit), .armed(blk_armed), .flag(match_flag)
    );

    ocu_wavegen u_wave (
        .clk(clk), .rst(rst), .pwm(pwm), .om(om), .hit(hit),
        .force_strobe(force_strobe), .tick(tick), .at_bottom(at_bottom),
        .pin_dir_out(pin_dir_out), .port_val(port_val),
        .wave_bit(ocx), .pin_out(pin_out)
    );

    assign irq = match_flag & irq_en;
endmodule

// File: rtl/ocu_channel_chk.sv
module ocu_channel_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic [W-1:0] cnt_val,
    input logic [1:0]   wave_mode,
    input logic [1:0]   out_mode,
    input logic         force_strobe,
    input logic         cnt_written,
    input logic         port_val,
    input logic         irq_ack,
    input logic         match_flag,
    input logic         pin_out,
    input logic [W-1:0] cmp_active,
    input logic         blk_armed,
    input logic         ocx
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!match_flag && !ocx && cmp_active == '0));

    assert_flag_on_match_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_val == cmp_active && !cnt_written && !blk_armed) |=> match_flag);

    assert_force_no_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (force_strobe && !tick && !match_flag) |=> !match_flag);

    assert_write_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        (cnt_written && !match_flag) |=> !match_flag);

    assert_pwm_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (wave_mode[1] && !tick) |=> $stable(cmp_active));

    assert_pwm_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (wave_mode[1] && out_mode == 2'd2 && tick && cnt_val == cmp_active
         && !cnt_written && !blk_armed) |=> !ocx);

    assert_pin_port_R8: assert property (@(posedge clk) disable iff (rst)
        (out_mode == 2'd0) |-> (pin_out == port_val));

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !tick) |=> !match_flag);

    assert_wave_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!tick && !force_strobe) |=> $stable(ocx));
endmodule

bind ocu_channel ocu_channel_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .cnt_val(cnt_val),
    .wave_mode(wave_mode), .out_mode(out_mode), .force_strobe(force_strobe),
    .cnt_written(cnt_written), .port_val(port_val), .irq_ack(irq_ack),
    .match_flag(match_flag), .pin_out(pin_out), .cmp_active(cmp_active),
    .blk_armed(blk_armed), .ocx(ocx)
);

// File: tb/sim_ocu_channel.sv
module sim_ocu_channel;
    localparam int W = 16;
    localparam int N = 30;
    localparam int WATCHDOG = 20000;

    logic clk = 1'b0;
    logic rst;
    logic tick, at_top, at_bottom, cmp_wr, force_strobe, cnt_written;
    logic pin_dir_out, port_val, irq_en, flag_clr, irq_ack;
    logic [W-1:0] cnt_val, cmp_wdata;
    logic [1:0] wave_mode, out_mode;
    logic match_flag, irq, pin_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ocu_channel u0 (
        .clk(clk), .rst(rst), .tick(tick), .cnt_val(cnt_val), .at_top(at_top),
        .at_bottom(at_bottom), .wave_mode(wave_mode), .out_mode(out_mode),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .force_strobe(force_strobe),
        .cnt_written(cnt_written), .pin_dir_out(pin_dir_out), .port_val(port_val),
        .irq_en(irq_en), .flag_clr(flag_clr), .irq_ack(irq_ack),
        .match_flag(match_flag), .irq(irq), .pin_out(pin_out)
    );

    typedef struct packed {
        logic [3:0]   req;
        logic [1:0]   wm;
        logic [1:0]   om;
        logic         wr;
        logic [W-1:0] wd;
        logic [W-1:0] cnt;
        logic         tk;
        logic         bot;
        logic         top;
        logic         frc;
        logic         cw;
        logic         clr;
        logic         ef;
        logic         ep;
    } vec_t;

    //                 req  wm   om   wr  wd       cnt      tk  bot top frc cw  clr ef  ep
    localparam vec_t TBL [N] = '{
        '{4'd6, 2'd0,2'd1,1'b1,16'd100,16'd0,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R6 direct write
        '{4'd2, 2'd0,2'd1,1'b0,16'd0,  16'd99, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R2 no match
        '{4'd3, 2'd0,2'd1,1'b0,16'd0,  16'd100,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1}, // R3 toggle
        '{4'd9, 2'd0,2'd1,1'b0,16'd0,  16'd0,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1}, // R9 clear
        '{4'd3, 2'd0,2'd2,1'b0,16'd0,  16'd100,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0}, // R3 clear, R10 new code
        '{4'd9, 2'd0,2'd3,1'b0,16'd0,  16'd100,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1}, // R9 set beats clr, R3 set
        '{4'd8, 2'd0,2'd0,1'b0,16'd0,  16'd100,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0}, // R8 port, R3 code 0
        '{4'd10,2'd0,2'd2,1'b0,16'd0,  16'd0,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1}, // R10 bit kept
        '{4'd4, 2'd0,2'd2,1'b0,16'd0,  16'd0,  1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0}, // R4 force clear
        '{4'd4, 2'd0,2'd1,1'b0,16'd0,  16'd0,  1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1}, // R4 force toggle
        '{4'd5, 2'd0,2'd1,1'b0,16'd0,  16'd100,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1}, // R5 arm
        '{4'd5, 2'd0,2'd1,1'b0,16'd0,  16'd100,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1}, // R5 blocked tick
        '{4'd5, 2'd0,2'd1,1'b0,16'd0,  16'd100,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0}, // R5 next tick matches
        '{4'd5, 2'd0,2'd1,1'b0,16'd0,  16'd100,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0}, // R5 same-cycle block
        '{4'd5, 2'd0,2'd1,1'b0,16'd0,  16'd100,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R5 following tick blocked
        '{4'd6, 2'd1,2'd3,1'b1,16'd5,  16'd0,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R6 write in clear-on-compare
        '{4'd3, 2'd1,2'd3,1'b0,16'd0,  16'd5,  1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1}, // R3 set
        '{4'd10,2'd2,2'd2,1'b1,16'd50, 16'd0,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1}, // R10 mode change keeps bit
        '{4'd6, 2'd2,2'd2,1'b0,16'd0,  16'd50, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1}, // R6 shadow not active yet
        '{4'd7, 2'd2,2'd2,1'b0,16'd0,  16'd5,  1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0}, // R7 match clears
        '{4'd6, 2'd2,2'd2,1'b0,16'd0,  16'd255,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0}, // R6 load at TOP
        '{4'd7, 2'd2,2'd2,1'b0,16'd0,  16'd0,  1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1}, // R7 BOTTOM sets
        '{4'd6, 2'd2,2'd2,1'b0,16'd0,  16'd50, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0}, // R6 new value in use
        '{4'd7, 2'd2,2'd3,1'b0,16'd0,  16'd0,  1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0}, // R7 inverted BOTTOM
        '{4'd7, 2'd2,2'd3,1'b0,16'd0,  16'd50, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1}, // R7 inverted match sets
        '{4'd4, 2'd2,2'd2,1'b0,16'd0,  16'd0,  1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1}, // R4 force ignored in PWM
        '{4'd7, 2'd2,2'd1,1'b0,16'd0,  16'd50, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1}, // R7 code 1 no action
        '{4'd6, 2'd2,2'd2,1'b1,16'd0,  16'd0,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1}, // R6 shadow write 0
        '{4'd6, 2'd2,2'd2,1'b0,16'd0,  16'd400,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1}, // R6 load 0 at TOP
        '{4'd7, 2'd2,2'd2,1'b0,16'd0,  16'd0,  1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0}  // R7 match beats BOTTOM
    };

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic idle();
        tick = 0; at_top = 0; at_bottom = 0; cmp_wr = 0; cmp_wdata = '0;
        force_strobe = 0; cnt_written = 0; flag_clr = 0; irq_ack = 0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        @(negedge clk);
        rst = 1; idle(); cnt_val = '0; wave_mode = 2'd0; out_mode = 2'd1;
        pin_dir_out = 1; port_val = 0; irq_en = 0;
        step(); step();
        @(negedge clk);
        rst = 0;
        #1;
        check("R1", "flag after reset", match_flag, 1'b0);
        check("R1", "pin after reset", pin_out, 1'b0);
        check("R9", "irq after reset", irq, 1'b0);

        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            wave_mode = TBL[i].wm; out_mode = TBL[i].om;
            cmp_wr = TBL[i].wr; cmp_wdata = TBL[i].wd; cnt_val = TBL[i].cnt;
            tick = TBL[i].tk; at_bottom = TBL[i].bot; at_top = TBL[i].top;
            force_strobe = TBL[i].frc; cnt_written = TBL[i].cw; flag_clr = TBL[i].clr;
            step();
            checks++;
            if (match_flag !== TBL[i].ef) begin
                errors++;
                $display("FAIL R%0d row %0d flag: actual %b expected %b",
                         TBL[i].req, i, match_flag, TBL[i].ef);
            end
            checks++;
            if (pin_out !== TBL[i].ep) begin
                errors++;
                $display("FAIL R%0d row %0d pin: actual %b expected %b",
                         TBL[i].req, i, pin_out, TBL[i].ep);
            end
        end

        // State now: flag 1, waveform bit 0, PWM mode
        @(negedge clk);
        idle(); out_mode = 2'd2; pin_dir_out = 0; port_val = 1;
        #1;
        check("R8", "pin as input shows port", pin_out, 1'b1);
        pin_dir_out = 1;
        #1;
        check("R8", "pin as output shows waveform bit", pin_out, 1'b0);
        irq_en = 1;
        #1;
        check("R9", "irq with enable", irq, 1'b1);
        irq_en = 0;
        #1;
        check("R9", "irq masked", irq, 1'b0);
        irq_en = 1; irq_ack = 1;
        step();
        check("R9", "ack clears flag", match_flag, 1'b0);
        check("R9", "irq gone after ack", irq, 1'b0);

        // Set waveform bit and flag, then reset mid-run
        @(negedge clk);
        idle(); wave_mode = 2'd0; out_mode = 2'd3; cmp_wr = 1; cmp_wdata = 16'd7;
        step();
        @(negedge clk);
        idle(); cnt_val = 16'd7; tick = 1;
        step();
        check("R2", "flag after tick match", match_flag, 1'b1);
        check("R3", "set action", pin_out, 1'b1);
        @(negedge clk);
        idle(); rst = 1;
        step();
        @(negedge clk);
        rst = 0; cnt_val = 16'd0; tick = 1;
        step();
        check("R1", "compare value back to 0 (tick at 0 matches)", match_flag, 1'b1);
        @(negedge clk);
        idle(); rst = 1;
        step();
        check("R1", "flag cleared by reset", match_flag, 1'b0);
        check("R1", "waveform bit cleared by reset", pin_out, 1'b0);
        @(negedge clk);
        rst = 0;

        done = 1'b1;
    end

    initial begin
        while (!done && cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule